// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed SPI master that issues one complete serial-flash command per software start. Software loads a command word (one opcode byte and a 24-bit flash address) and an optional data word, then writes the control register with a transmit byte count, a receive byte count and the start bit. The engine lowers chip select, sends the transmit bytes, clocks in the receive bytes and releases chip select. A busy flag in the control register covers the whole transaction.

One transaction carries up to eight outgoing bytes and up to four incoming bytes. The first four outgoing bytes come from the command word and the next four come from the data word. This covers the usual flash commands: status and signature reads, a word read, sector erase, and a page program of up to four bytes. Received bytes are placed in the data word, right-aligned, so software only has to mask the result to the receive count. The serial clock runs in SPI mode 0 at the system clock divided by the parameter `SCK_DIV`, which must be even and at least 2.

Top module: `sflash_cmd_engine`

## Requirements
- R1: Three word registers are decoded at byte offsets 0x0 (control), 0x4 (command word) and 0x8 (data word). Any other offset reads 0, and writes to it change nothing. After reset all registers read 0, `cs_no` is high and `sclk_o` is low.
- R2: Control bits [3:0] hold the transmit byte count, which includes the opcode byte. Bits [7:4] hold the receive byte count. Writing 1 to bit 8 starts a transaction, and bit 8 always reads 0. Bit 16 reads 1 while a transaction runs. Both count fields read back exactly as written, including after completion.
- R3: The transmit bytes go out in this order: command bits [7:0], [31:24], [23:16], [15:8], then data bits [7:0], [15:8], [23:16], [31:24]. Each byte is sent MSB first, and the stream stops after the transmit count. A transmit count above 8 acts as 8.
- R4: Receive starts only after the last transmit bit. Each received byte is taken MSB first from `miso_i`, sampled on the rising edge of `sclk_o`. At completion the first received byte is in data bits [7:0], the next in [15:8], and so on. Data bytes above the receive count read 0. A receive count above 4 acts as 4. A receive count of 0 leaves the data word unchanged.
- R5: The serial clock runs in SPI mode 0. `sclk_o` idles low and gives exactly 8 × (tx + rx) rising edges per transaction. `mosi_o` changes only while `sclk_o` is low. Each bit lasts `SCK_DIV` system clocks.
- R6: A start with a non-zero transmit count sets busy and drives `cs_no` low on the next clock. Chip select stays low until the last bit has finished. Busy lasts exactly 8 × (tx + rx) × `SCK_DIV` clocks and then clears, at which point `cs_no` returns high.
- R7: While busy, every register write is ignored. This covers the start bit, the count fields, the command word and the data word.
- R8: A start with a transmit count of 0 completes at once. `cs_no` never goes low, busy never reads 1 and the data word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| sclk_o | output | 1 | Serial clock, mode 0 |
| cs_no | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench runs every combination of transmit counts 0 to 8 with receive counts 0 to 4, and adds counts above the limits. A device model feeds a random bit pattern on `miso_i`, and for each run the bench checks the captured MOSI byte order, the edge count, the busy length and the right-aligned result. These runs would expose an engine that swaps the address byte order or starts receiving early, since that shifts the result by whole bytes. They would also expose one that packs the first received byte at the top of the word, or one that fails to clamp oversized counts and so runs past 96 bits. Further runs write the control, command and data registers in the middle of a transaction; an engine that honours those writes would restart, send changed bytes or change the count fields. A zero transmit count must leave chip select idle, so a missing guard shows up as a spurious chip-select pulse.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 4;
  localparam int MAX_TX    = 8;
  localparam int MAX_RX    = 4;
  localparam int CMD_BYTES = 4;
  localparam int MAX_BITS  = (MAX_TX + MAX_RX) * 8;
  localparam int IDX_W     = $clog2(MAX_BITS);
  localparam int TXS_W     = $clog2(MAX_TX);

  localparam int OFS_CTL = 'h0;
  localparam int OFS_CMD = 'h4;
  localparam int OFS_DAT = 'h8;

  localparam int TXC_LSB   = 0;
  localparam int RXC_LSB   = 4;
  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;

  function automatic logic [CNT_W-1:0] clamp_cnt(logic [CNT_W-1:0] v, int lim);
    return (int'(v) > lim) ? CNT_W'(lim) : v;
  endfunction
endpackage

// File: rtl/sfe_sclk_gen.sv
module sfe_sclk_gen #(
  parameter int SCK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = SCK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfe_regs.sv
module sfe_regs
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_sr_i,
  output logic              start_o,
  output logic [CNT_W-1:0]  tx_eff_o,
  output logic [CNT_W-1:0]  rx_eff_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [CNT_W-1:0]  tx_q, rx_q;
  logic [WORD_W-1:0] cmd_q, data_q, data_rx, ctl_rd;
  logic              sel_ctl, sel_cmd, sel_dat, wr_ok;

  assign sel_ctl = (addr_i == ADDR_W'(OFS_CTL));
  assign sel_cmd = (addr_i == ADDR_W'(OFS_CMD));
  assign sel_dat = (addr_i == ADDR_W'(OFS_DAT));
  assign wr_ok   = wr_en_i && !busy_i;

  assign start_o  = wr_ok && sel_ctl && wdata_i[START_BIT] &&
                    (wdata_i[TXC_LSB +: CNT_W] != '0);
  assign tx_eff_o = clamp_cnt(tx_q, MAX_TX);
  assign rx_eff_o = clamp_cnt(rx_q, MAX_RX);
  assign cmd_o    = cmd_q;
  assign data_o   = data_q;

  // collected bits hold the first byte highest; flip to right-aligned order
  always_comb begin
    data_rx = '0;
    for (int k = 0; k < MAX_RX; k++) begin
      if (k < int'(rx_eff_o))
        data_rx[8*k +: 8] = rx_sr_i[8*(int'(rx_eff_o) - 1 - k) +: 8];
    end
  end

  always_comb begin
    ctl_rd                     = '0;
    ctl_rd[TXC_LSB +: CNT_W]   = tx_q;
    ctl_rd[RXC_LSB +: CNT_W]   = rx_q;
    ctl_rd[BUSY_BIT]           = busy_i;
    if (sel_ctl)      rdata_o = ctl_rd;
    else if (sel_cmd) rdata_o = cmd_q;
    else if (sel_dat) rdata_o = data_q;
    else              rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cmd_q  <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      if (sel_ctl) begin
        tx_q <= wdata_i[TXC_LSB +: CNT_W];
        rx_q <= wdata_i[RXC_LSB +: CNT_W];
      end
      if (sel_cmd) cmd_q  <= wdata_i;
      if (sel_dat) data_q <= wdata_i;
    end else if (done_i && (rx_eff_o != '0)) begin
      data_q <= data_rx;
    end
  end
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
  import sfe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  tx_eff_i,
  input  logic [CNT_W-1:0]  rx_eff_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_sr_o
);
  logic [7:0]        tx_byte [MAX_TX];
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W:0]    n_bits, tx_bits;
  logic              busy_q, cs_nq, in_tx, last;
  logic [WORD_W-1:0] rx_sr_q;

  // command word: opcode first, then address high to low; data word LSB first
  for (genvar i = 0; i < MAX_TX; i++) begin : g_txb
    if (i == 0) begin : g_op
      assign tx_byte[i] = cmd_i[7:0];
    end else if (i < CMD_BYTES) begin : g_adr
      assign tx_byte[i] = cmd_i[WORD_W-1-8*(i-1) -: 8];
    end else begin : g_dat
      assign tx_byte[i] = data_i[8*(i-CMD_BYTES) +: 8];
    end
  end

  assign n_bits  = (IDX_W+1)'((int'(tx_eff_i) + int'(rx_eff_i)) * 8);
  assign tx_bits = (IDX_W+1)'(int'(tx_eff_i) * 8);
  assign in_tx   = ({1'b0, idx_q} < tx_bits);
  assign last    = ({1'b0, idx_q} == n_bits - 1'b1);

  assign mosi_o  = busy_q && in_tx && tx_byte[idx_q[3 +: TXS_W]][~idx_q[2:0]];
  assign done_o  = busy_q && fall_i && last;
  assign busy_o  = busy_q;
  assign cs_no   = cs_nq;
  assign rx_sr_o = rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cs_nq   <= 1'b1;
      idx_q   <= '0;
      rx_sr_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      cs_nq   <= 1'b0;
      idx_q   <= '0;
      rx_sr_q <= '0;
    end else if (busy_q) begin
      if (rise_i && !in_tx)
        rx_sr_q <= {rx_sr_q[WORD_W-2:0], miso_i};
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
          cs_nq  <= 1'b1;
          idx_q  <= '0;
        end else begin
          idx_q  <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfe_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int SCK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic              start, busy, done, rise, fall;
  logic [CNT_W-1:0]  tx_eff, rx_eff;
  logic [WORD_W-1:0] cmd_w, data_w, rx_sr;

  sfe_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .busy_i   (busy),
    .done_i   (done),
    .rx_sr_i  (rx_sr),
    .start_o  (start),
    .tx_eff_o (tx_eff),
    .rx_eff_o (rx_eff),
    .cmd_o    (cmd_w),
    .data_o   (data_w),
    .rdata_o  (rdata_o)
  );

  sfe_sclk_gen #(.SCK_DIV(SCK_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sfe_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tx_eff_i (tx_eff),
    .rx_eff_i (rx_eff),
    .cmd_i    (cmd_w),
    .data_i   (data_w),
    .rise_i   (rise),
    .fall_i   (fall),
    .miso_i   (miso_i),
    .busy_o   (busy),
    .cs_no    (cs_no),
    .mosi_o   (mosi_o),
    .done_o   (done),
    .rx_sr_o  (rx_sr)
  );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_wr_i,
  input logic       start_bit_i,
  input logic [3:0] tx_field_i,
  input logic       busy_i,
  input logic       cs_ni,
  input logic       sclk_i,
  input logic       mosi_i,
  input logic [3:0] tx_eff_i
);
  assert_sclk_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sclk_i);

  assert_mosi_at_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> $stable(mosi_i));

  assert_mosi_while_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && $past(sclk_i)) |-> $stable(mosi_i));

  assert_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && start_bit_i && (tx_field_i != 4'd0) && !busy_i) |=> (busy_i && !cs_ni));

  assert_zero_tx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && start_bit_i && (tx_field_i == 4'd0) && !busy_i) |=> (cs_ni && !busy_i));

  assert_hold_counts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(tx_eff_i));
endmodule

bind sflash_cmd_engine sfe_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_wr_i    (wr_en_i && (addr_i == ADDR_W'(sfe_pkg::OFS_CTL))),
  .start_bit_i (wdata_i[sfe_pkg::START_BIT]),
  .tx_field_i  (wdata_i[3:0]),
  .busy_i      (busy),
  .cs_ni       (cs_no),
  .sclk_i      (sclk_o),
  .mosi_i      (mosi_o),
  .tx_eff_i    (tx_eff)
);

// File: tb/sflash_cmd_engine_test.sv
module sflash_cmd_engine_test;
  localparam int ADDR_W  = 4;
  localparam int SCK_DIV = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              sclk, cs_n, mosi, miso;

  int n_checks = 0;
  int n_err    = 0;

  always #4 clk = ~clk;

  sflash_cmd_engine #(.ADDR_W(ADDR_W), .SCK_DIV(SCK_DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  // device model: captures mosi on rise, presents pattern bits advanced on fall
  logic [95:0] mosi_cap = '0;
  logic [95:0] pat = '0;
  int rise_cnt = 0, fall_cnt = 0, cs_falls = 0, fall_base = 0;

  always @(posedge sclk) begin
    mosi_cap = {mosi_cap[94:0], mosi};
    rise_cnt++;
  end
  always @(negedge sclk) fall_cnt++;
  always @(negedge cs_n) cs_falls++;

  function automatic logic pick(logic [95:0] p, int f);
    if (f < 0 || f > 95) return 1'b0;
    return p[95 - f];
  endfunction
  assign miso = pick(pat, fall_cnt - fall_base);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  function automatic logic [7:0] exp_byte(int i, logic [31:0] c, logic [31:0] d);
    case (i)
      0: return c[7:0];
      1: return c[31:24];
      2: return c[23:16];
      3: return c[15:8];
      default: return d[8*(i-4) +: 8];
    endcase
  endfunction

  task automatic xfer(input int txw, input int rxw, input bit inject);
    logic [31:0] c, d, v;
    logic [63:0] exp_tx, act_tx;
    logic [31:0] exp_dat;
    int txe, rxe, nb, bcnt, r0, c0;
    bit b;
    c = $urandom;
    d = $urandom;
    bus_write('h4, c);
    bus_write('h8, d);
    pat = {$urandom, $urandom, $urandom};
    fall_base = fall_cnt;
    r0 = rise_cnt;
    c0 = cs_falls;
    txe = (txw > 8) ? 8 : txw;
    rxe = (rxw > 4) ? 4 : rxw;
    nb  = (txe == 0) ? 0 : 8 * (txe + rxe);
    @(negedge clk);
    wr_en = 1'b1; addr = '0; wdata = {23'd0, 1'b1, 4'(rxw), 4'(txw)};
    @(negedge clk);
    wr_en = 1'b0;
    bcnt = 0;
    forever begin
      b = (addr == '0) ? rdata[16] : 1'b1;
      if (!b || bcnt > 4000) break;
      bcnt++;
      if (inject) begin
        // R7: writes to every register in mid-transaction must be dropped
        case (bcnt)
          3: begin wr_en = 1'b1; addr = 'h4; wdata = ~c; end
          4: begin addr = 'h8; wdata = ~d; end
          5: begin addr = '0; wdata = 32'h0000_01F5; end
          6: begin wr_en = 1'b0; addr = '0; end
          default: ;
        endcase
      end
      @(negedge clk);
    end
    exp_tx = '0; act_tx = '0;
    for (int i = 0; i < txe; i++) begin
      exp_tx[63-8*i -: 8] = exp_byte(i, c, d);
      act_tx[63-8*i -: 8] = mosi_cap[nb-1-8*i -: 8];
    end
    check(exp_tx == act_tx, "R3", $sformatf("tx bytes tx=%0d rx=%0d", txw, rxw), act_tx, exp_tx);
    check(rise_cnt - r0 == nb, "R5", $sformatf("sclk rises tx=%0d rx=%0d", txw, rxw),
          64'(rise_cnt - r0), 64'(nb));
    check(bcnt == nb * SCK_DIV, "R6", $sformatf("busy cycles tx=%0d rx=%0d", txw, rxw),
          64'(bcnt), 64'(nb * SCK_DIV));
    check(cs_falls - c0 == ((txe == 0) ? 0 : 1), (txe == 0) ? "R8" : "R6",
          $sformatf("cs assertions tx=%0d", txw), 64'(cs_falls - c0), 64'((txe == 0) ? 0 : 1));
    if (txe == 0 || rxe == 0) exp_dat = d;
    else begin
      exp_dat = '0;
      for (int k = 0; k < rxe; k++) exp_dat[8*k +: 8] = pat[95-8*(txe+k) -: 8];
    end
    bus_read('h8, v);
    check(v == exp_dat, (rxe == 0 || txe == 0) ? "R8" : "R4",
          $sformatf("data word tx=%0d rx=%0d", txw, rxw), 64'(v), 64'(exp_dat));
    bus_read('h0, v);
    check(v == {24'd0, 4'(rxw), 4'(txw)}, inject ? "R7" : "R2",
          $sformatf("ctl readback tx=%0d rx=%0d", txw, rxw), 64'(v), 64'({24'd0, 4'(rxw), 4'(txw)}));
    check(cs_n == 1'b1 && sclk == 1'b0, "R6", "idle lines after transfer",
          64'({cs_n, sclk}), 64'(2'b10));
    addr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R6: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    bus_read('h0, v); check(v == 0, "R1", "ctl after reset", 64'(v), 0);
    bus_read('h4, v); check(v == 0, "R1", "cmd after reset", 64'(v), 0);
    bus_read('h8, v); check(v == 0, "R1", "data after reset", 64'(v), 0);
    check(cs_n == 1'b1 && sclk == 1'b0, "R1", "lines after reset", 64'({cs_n, sclk}), 64'(2'b10));
    // R1: unmapped offset and round trip
    bus_write('hC, 32'hDEAD_BEEF);
    bus_read('hC, v); check(v == 0, "R1", "unmapped offset read", 64'(v), 0);
    bus_read('h4, v); check(v == 0, "R1", "cmd untouched by unmapped write", 64'(v), 0);
    bus_write('h4, 32'h1234_5678);
    bus_read('h4, v); check(v == 32'h1234_5678, "R1", "cmd round trip", 64'(v), 64'h1234_5678);
    // R2: start bit reads 0, counts stored
    bus_write('h0, 32'h0000_0010);
    bus_read('h0, v); check(v == 32'h10, "R2", "ctl without start", 64'(v), 64'h10);
    // full sweep of counts
    for (int t = 0; t <= 8; t++)
      for (int r = 0; r <= 4; r++)
        xfer(t, r, 1'b0);
    // counts above limits (R3, R4 clamping)
    xfer(12, 7, 1'b0);
    xfer(15, 0, 1'b0);
    xfer(1, 9, 1'b0);
    xfer(0, 4, 1'b0);
    // writes during busy (R7)
    xfer(2, 0, 1'b1);
    xfer(4, 2, 1'b1);
    xfer(8, 4, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule